// File: doc/BRIEF.md
# Halfword Packet Transmit Channel

This block feeds a 16-bit point-to-point link from packets held in a word-addressed memory of 36-bit words. Each word carries two 16-bit halfwords. The channel moves forward only when the link handshake reports that the previous halfword was taken (an output-done event). On each such event it sends one halfword. When it has nothing in flight, it serves the queues in memory instead.

Packets wait on a linked ready queue and are retired onto a done queue. A queue is described by one header word: its left field holds the first packet and its right field holds the last. Each packet begins with a header word, whose left field holds the halfword length and whose right field holds the link to the next packet. The payload words follow the header. To start a packet, the channel sends its length to the peer, unlinks the packet from the ready queue and records it in an in-progress slot. The packet's payload follows, one halfword per event. On the first event after the payload, the in-progress packet is moved to the done queue and the next packet is started.

If the ready queue is found empty, the channel clears its own enable. Software refills the queue and issues a start pulse to resume. The memory port has a fixed one-cycle read latency. It is assumed to be granted without arbitration. The handshake block is assumed to raise output-done only while the channel waits, which is at least 12 cycles after the previous event.

Top module: `hw_pkt_tx`

## Requirements
- R1: After reset, `send_req`, `mem_req` and `out_en` are low and the halfword count is zero.
- R2: A `start` pulse sets `out_en`. If the count is zero at that time, the channel at once serves the queues as if an enabled output-done event had arrived.
- R3: A payload word sends bits [31:16] first and bits [15:0] second. Bits [35:32] never reach `send_data`. The second halfword comes from a buffer filled when the word was read.
- R4: Each payload memory word is read exactly once. The halfword pointer is twice the word address, and its bit 0 selects the half. The first payload word is the word after the packet header.
- R5: An output-done event with count zero and `out_en` low causes no memory access and no send, and leaves `out_en` low.
- R6: Starting a packet does the following. It sends the header's length (bits [33:18]) as the first halfword. It writes the header back with its link field (bits [17:0]) zeroed. It writes the ready-queue header as {old link, old last}, or as all zeros when the link is zero. It writes the packet's header address into the in-progress slot.
- R7: An output-done event with a nonzero count decrements the count and sends one payload halfword. A packet of length L therefore sends exactly L payload halfwords after its length.
- R8: When serving the queues, a nonzero in-progress slot is cleared to zero and its packet is appended to the done queue. An empty done queue (left field zero) becomes {pkt, pkt}. Otherwise the done-queue header becomes {first, pkt} and the old last packet's link field becomes pkt.
- R9: When the ready-queue header's left field is zero during service, `out_en` is cleared and nothing is sent.
- R10: A zero-length packet sends only its length halfword (0). It is retired on the next output-done event.
- R11: The queue words sit at parameter addresses. By default the ready-queue header is at 0x10, the done-queue header at 0x11 and the in-progress slot at 0x12. Addresses use 18 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| done_evt | input | 1 | One-cycle output-done event from the link handshake |
| start | input | 1 | One-cycle pulse that re-enables the channel |
| mem_rdata | input | 36 | Read data, valid the cycle after a read request |
| send_req | output | 1 | One-cycle request to send `send_data` on the link |
| send_data | output | 16 | Halfword to send |
| out_en | output | 1 | Channel enable, cleared by the channel when the ready queue is empty |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | 18 | Word address |
| mem_wdata | output | 36 | Write data |

## Verification
The assertions check several behaviours on every cycle:
- the length halfword taken from the header as it is read;
- the high half of a payload word sent the cycle after the read;
- a disabled, idle channel staying quiet on an event;
- the enable dropping when the ready queue is found empty;
- the count falling by exactly one per payload event, never from zero.

The bench's scenarios show what spans many events:
- the order of the whole halfword stream across packets, including a zero-length packet;
- the memory images of both queues after append and unlink;
- the cleared link fields;
- resumption by a start pulse after the queue runs dry.

// File: rtl/txq_pkg.sv
// Package for the halfword packet transmit channel.
// Holds the controller state encoding shared by the modules.
package txq_pkg;

    // Controller states: one wait state, one payload read, and the queue-service sequence.
    typedef enum logic [3:0] {
        S_WAIT,     // waiting for an output-done event or start
        S_PAY,      // payload word returning from memory
        S_IP,       // in-progress slot returning
        S_DQ_RD,    // read done-queue header
        S_DQ,       // done-queue header returning
        S_LINK_RD,  // read old last packet of the done queue
        S_LINK,     // old last packet header returning
        S_RQ_RD,    // read ready-queue header
        S_RQ,       // ready-queue header returning
        S_HDR,      // first ready packet header returning
        S_RQ_WR,    // write advanced ready-queue header
        S_IP_WR     // record new packet in the in-progress slot
    } txq_state_e;

endpackage

// File: rtl/txq_cursor.sv
// Halfword count and halfword pointer of the packet being sent.
// Assumes: load and step are never high together, and step only
// arrives while the count is nonzero (the controller gates it).
module txq_cursor #(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned PTR_W = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_cnt,
    input  logic [PTR_W-1:0] load_ptr,
    input  logic             step,
    output logic             cnt_zero,
    output logic             half_odd,
    output logic [PTR_W-2:0] word_addr
);

    logic [CNT_W-1:0] cnt;
    logic [PTR_W-1:0] ptr;

    // Load on packet start, otherwise count down and advance per payload halfword.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            ptr <= '0;
        end else if (load) begin
            cnt <= load_cnt;
            ptr <= load_ptr;
        end else if (step) begin
            cnt <= cnt - 1'b1;
            ptr <= ptr + 1'b1;
        end
    end

    assign cnt_zero  = (cnt == '0);
    assign half_odd  = ptr[0];
    assign word_addr = ptr[PTR_W-1:1];

    // R7: every payload step lowers the count by exactly one
    p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (cnt == $past(cnt) - 1'b1));

    // R7: the controller never steps an idle (zero) count
    p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> !cnt_zero);

endmodule

// File: rtl/txq_unpack.sv
// Splits a payload word into two halfwords. The high half goes out at
// once and the low half is held for the next event.
// Assumes: ld is high in the cycle the payload word is on word_in.
module txq_unpack #(
    parameter int unsigned HALF_W = 16,
    parameter int unsigned WORD_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld,
    input  logic [WORD_W-1:0] word_in,
    output logic [HALF_W-1:0] first_half,
    output logic [HALF_W-1:0] held_half
);

    assign first_half = word_in[2*HALF_W-1:HALF_W];

    // Capture the second halfword so that the word is read only once.
    always_ff @(posedge clk) begin
        if (!rst_n)  held_half <= '0;
        else if (ld) held_half <= word_in[HALF_W-1:0];
    end

endmodule

// File: rtl/hw_pkt_tx.sv
// Halfword packet transmit channel.
// Sends packets from a linked ready queue in 36-bit word memory as
// 16-bit halfwords, one per output-done event: the length first, then
// the payload. It retires finished packets to a done queue.
// Assumes: memory read data arrives one cycle after the request and is
// never stalled; done_evt only arrives while the controller waits.
module hw_pkt_tx
    import txq_pkg::*;
#(
    parameter int unsigned LINK_W = 18,
    parameter int unsigned HALF_W = 16,
    parameter logic [LINK_W-1:0] READY_HDR = 'h10,
    parameter logic [LINK_W-1:0] DONE_HDR  = 'h11,
    parameter logic [LINK_W-1:0] CUR_SLOT  = 'h12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                done_evt,
    input  logic                start,
    input  logic [2*LINK_W-1:0] mem_rdata,
    output logic                send_req,
    output logic [HALF_W-1:0]   send_data,
    output logic                out_en,
    output logic                mem_req,
    output logic                mem_we,
    output logic [LINK_W-1:0]   mem_addr,
    output logic [2*LINK_W-1:0] mem_wdata
);

    localparam int unsigned WORD_W = 2 * LINK_W;
    localparam int unsigned PTR_W  = LINK_W + 1;

    txq_state_e        st;
    logic [LINK_W-1:0] pkt;    // packet being retired or started
    logic [LINK_W-1:0] tail;   // old last entry of the queue being edited
    logic [LINK_W-1:0] nxt;    // link of the packet being started

    logic              cnt_zero;
    logic              half_odd;
    logic [LINK_W-1:0] word_addr;
    logic [HALF_W-1:0] first_half;
    logic [HALF_W-1:0] held_half;

    logic [LINK_W-1:0] rd_left;
    logic [LINK_W-1:0] rd_right;
    logic [HALF_W-1:0] rd_len;
    logic              ev_step;
    logic              ev_idle;

    assign rd_left  = mem_rdata[WORD_W-1:LINK_W];
    assign rd_right = mem_rdata[LINK_W-1:0];
    assign rd_len   = mem_rdata[LINK_W+HALF_W-1:LINK_W];

    // A payload event while a packet is active, or queue service when idle.
    assign ev_step = (st == S_WAIT) && done_evt && !cnt_zero;
    assign ev_idle = (st == S_WAIT) && cnt_zero && (start || (done_evt && out_en));

    txq_cursor #(
        .CNT_W (HALF_W),
        .PTR_W (PTR_W)
    ) u_cursor (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (st == S_HDR),
        .load_cnt  (rd_len),
        .load_ptr  ({pkt + LINK_W'(1), 1'b0}),
        .step      (ev_step),
        .cnt_zero  (cnt_zero),
        .half_odd  (half_odd),
        .word_addr (word_addr)
    );

    txq_unpack #(
        .HALF_W (HALF_W),
        .WORD_W (WORD_W)
    ) u_unpack (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld         (st == S_PAY),
        .word_in    (mem_rdata),
        .first_half (first_half),
        .held_half  (held_half)
    );

    // Memory request for the current state.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (st)
            S_WAIT: begin
                if (ev_step && !half_odd) begin
                    mem_req  = 1'b1;
                    mem_addr = word_addr;
                end else if (ev_idle) begin
                    mem_req  = 1'b1;
                    mem_addr = CUR_SLOT;
                end
            end
            S_IP: begin
                mem_req = 1'b1;
                if (rd_right != '0) begin
                    mem_we   = 1'b1;
                    mem_addr = CUR_SLOT;
                end else begin
                    mem_addr = READY_HDR;
                end
            end
            S_DQ_RD: begin
                mem_req  = 1'b1;
                mem_addr = DONE_HDR;
            end
            S_DQ: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = DONE_HDR;
                mem_wdata = (rd_left == '0) ? {pkt, pkt} : {rd_left, pkt};
            end
            S_LINK_RD: begin
                mem_req  = 1'b1;
                mem_addr = tail;
            end
            S_LINK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = tail;
                mem_wdata = {rd_left, pkt};
            end
            S_RQ_RD: begin
                mem_req  = 1'b1;
                mem_addr = READY_HDR;
            end
            S_RQ: begin
                if (rd_left != '0) begin
                    mem_req  = 1'b1;
                    mem_addr = rd_left;
                end
            end
            S_HDR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = pkt;
                mem_wdata = {rd_left, {LINK_W{1'b0}}};
            end
            S_RQ_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = READY_HDR;
                mem_wdata = (nxt == '0) ? '0 : {nxt, tail};
            end
            S_IP_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = CUR_SLOT;
                mem_wdata = {{LINK_W{1'b0}}, pkt};
            end
            default: ;
        endcase
    end

    // Controller sequencing, enable flag and registered send outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= S_WAIT;
            out_en    <= 1'b0;
            pkt       <= '0;
            tail      <= '0;
            nxt       <= '0;
            send_req  <= 1'b0;
            send_data <= '0;
        end else begin
            send_req <= 1'b0;
            if (start) out_en <= 1'b1;
            case (st)
                S_WAIT: begin
                    if (ev_step) begin
                        if (half_odd) begin
                            send_req  <= 1'b1;
                            send_data <= held_half;
                        end else begin
                            st <= S_PAY;
                        end
                    end else if (ev_idle) begin
                        st <= S_IP;
                    end
                end
                S_PAY: begin
                    send_req  <= 1'b1;
                    send_data <= first_half;
                    st        <= S_WAIT;
                end
                S_IP: begin
                    if (rd_right != '0) begin
                        pkt <= rd_right;
                        st  <= S_DQ_RD;
                    end else begin
                        st  <= S_RQ;
                    end
                end
                S_DQ_RD: st <= S_DQ;
                S_DQ: begin
                    if (rd_left == '0) begin
                        st <= S_RQ_RD;
                    end else begin
                        tail <= rd_right;
                        st   <= S_LINK_RD;
                    end
                end
                S_LINK_RD: st <= S_LINK;
                S_LINK:    st <= S_RQ_RD;
                S_RQ_RD:   st <= S_RQ;
                S_RQ: begin
                    if (rd_left == '0) begin
                        out_en <= 1'b0;
                        st     <= S_WAIT;
                    end else begin
                        pkt  <= rd_left;
                        tail <= rd_right;
                        st   <= S_HDR;
                    end
                end
                S_HDR: begin
                    send_req  <= 1'b1;
                    send_data <= rd_len;
                    nxt       <= rd_right;
                    st        <= S_RQ_WR;
                end
                S_RQ_WR: st <= S_IP_WR;
                S_IP_WR: st <= S_WAIT;
                default: st <= S_WAIT;
            endcase
        end
    end

    // R5: an event on an idle, disabled channel sends nothing and stays waiting
    p_disabled_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_WAIT && done_evt && !start && !out_en && cnt_zero)
        |-> !mem_req ##1 (st == S_WAIT && !send_req && !out_en));

    // R6: the length halfword is the header's left field, sent the next cycle
    p_len_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_HDR) |=> (send_req && send_data == $past(rd_len)));

    // R3: the high half of a fresh payload word goes out right after the read
    p_high_half_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_PAY) |=> (send_req && send_data == $past(mem_rdata[2*HALF_W-1:HALF_W])));

    // R9: an empty ready queue drops the enable and sends nothing
    p_dry_disable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_RQ && rd_left == '0 && !start) |=> (!out_en && !send_req && st == S_WAIT));

endmodule

// File: tb/hw_pkt_tx_bench.sv
`timescale 1ns/1ps
module hw_pkt_tx_bench;

    localparam int unsigned LW = 18;
    localparam logic [17:0] RDY = 18'h10;
    localparam logic [17:0] DNQ = 18'h11;
    localparam logic [17:0] CUR = 18'h12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        done_evt = 1'b0;
    logic        start = 1'b0;
    logic [35:0] mem_rdata;
    logic        send_req;
    logic [15:0] send_data;
    logic        out_en;
    logic        mem_req;
    logic        mem_we;
    logic [17:0] mem_addr;
    logic [35:0] mem_wdata;

    logic [35:0] mem [0:255];

    int checks = 0;
    int errors = 0;
    int sends  = 0;
    bit finished = 1'b0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    hw_pkt_tx u_hw_pkt_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .done_evt  (done_evt),
        .start     (start),
        .mem_rdata (mem_rdata),
        .send_req  (send_req),
        .send_data (send_data),
        .out_en    (out_en),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    // Memory model with one-cycle read latency.
    always @(posedge clk) begin
        if (mem_req && mem_we) mem[mem_addr[7:0]] <= mem_wdata;
        if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[7:0]];
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: pop and compare each halfword the design sends.
    always @(negedge clk) begin
        if (rst_n && send_req) begin
            sends++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R5 unexpected send", 64'(send_data), 64'hffff_ffff);
            end else begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(send_data == e, t, 64'(send_data), 64'(e));
            end
        end
    end

    task automatic push(input logic [15:0] v, input string t);
        exp_q.push_back(v);
        tag_q.push_back(t);
    endtask

    // Build a packet: header {len, link}, payload words with junk in [35:32].
    task automatic load_pkt(input int a, input int len, input int link);
        mem[a] = {2'b00, 16'(len), 18'(link)};
        for (int i = 0; i < (len + 1) / 2; i++) begin
            logic [15:0] hi;
            hi = 16'((a + i + 1) * 16'h0101) ^ 16'h5000;
            mem[a + 1 + i] = {4'hA, hi, ~hi};
        end
    endtask

    // Expected stream of one packet: length first (R6), then payload halves (R3, R4, R7).
    task automatic expect_pkt(input int a);
        int len;
        len = int'(mem[a][33:18]);
        push(16'(len), "R6 length first");
        for (int i = 0; i < len; i++) begin
            logic [35:0] w;
            w = mem[a + 1 + i / 2];
            if (i % 2 == 0) push(w[31:16], "R3 high half first");
            else            push(w[15:0],  "R4 buffered low half");
        end
    endtask

    task automatic pulse_done();
        @(negedge clk) done_evt = 1'b1;
        @(negedge clk) done_evt = 1'b0;
        repeat (20) @(negedge clk);
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (20) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int s;
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (4) @(negedge clk);
        // R1: reset state
        check(!send_req && !mem_req && !out_en, "R1 reset outputs", {61'd0, send_req, mem_req, out_en}, 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!send_req && !mem_req && !out_en, "R1 idle after reset", {61'd0, send_req, mem_req, out_en}, 64'd0);

        // Packets A(3) -> B(4) -> C(0) on the ready queue (R11 addresses).
        load_pkt(32'h20, 3, 32'h30);
        load_pkt(32'h30, 4, 32'h40);
        load_pkt(32'h40, 0, 0);
        mem[RDY] = {18'h20, 18'h40};

        // R5: event while disabled does nothing
        s = sends;
        pulse_done();
        check(sends == s, "R5 no send when disabled", 64'(sends), 64'(s));
        check(mem[RDY] == {18'h20, 18'h40}, "R5 ready queue untouched", 64'(mem[RDY]), 64'({18'h20, 18'h40}));
        check(mem[CUR] == 0 && !out_en, "R5 slot and enable untouched", 64'(mem[CUR]), 64'd0);

        // R2: start enables and immediately starts packet A
        expect_pkt(32'h20);
        expect_pkt(32'h30);
        expect_pkt(32'h40);
        pulse_start();
        check(out_en == 1'b1, "R2 start sets enable", 64'(out_en), 64'd1);
        check(mem[RDY] == {18'h30, 18'h40}, "R6 ready head advanced", 64'(mem[RDY]), 64'({18'h30, 18'h40}));
        check(mem[32'h20] == {2'b00, 16'd3, 18'h0}, "R6 link cleared", 64'(mem[32'h20]), 64'({2'b00, 16'd3, 18'h0}));
        check(mem[CUR] == 36'h20, "R6 in-progress recorded", 64'(mem[CUR]), 64'h20);
        check(sends == s + 1, "R6 only length sent at start", 64'(sends), 64'(s + 1));

        // R7: three payload events for A, then one more to retire A and start B
        for (int i = 0; i < 3; i++) pulse_done();
        check(sends == s + 4, "R7 L payload halfwords", 64'(sends), 64'(s + 4));
        pulse_done();
        check(mem[DNQ] == {18'h20, 18'h20}, "R8 append to empty done queue", 64'(mem[DNQ]), 64'({18'h20, 18'h20}));
        check(mem[CUR] == 36'h30, "R8 slot holds next packet", 64'(mem[CUR]), 64'h30);

        // B payload, then retire B and start zero-length C
        for (int i = 0; i < 4; i++) pulse_done();
        pulse_done();
        check(mem[DNQ] == {18'h20, 18'h30}, "R8 append to tail", 64'(mem[DNQ]), 64'({18'h20, 18'h30}));
        check(mem[32'h20][17:0] == 18'h30, "R8 old tail linked", 64'(mem[32'h20][17:0]), 64'h30);
        check(mem[RDY] == 36'h0, "R6 ready emptied on zero link", 64'(mem[RDY]), 64'd0);

        // R10: C sends only its length; next event retires it, R9: queue dry
        s = sends;
        pulse_done();
        check(sends == s, "R10 zero length no payload", 64'(sends), 64'(s));
        check(out_en == 1'b0, "R9 enable cleared when dry", 64'(out_en), 64'd0);
        check(mem[DNQ] == {18'h20, 18'h40}, "R10 zero length retired", 64'(mem[DNQ]), 64'({18'h20, 18'h40}));
        check(mem[CUR] == 36'h0, "R8 slot cleared", 64'(mem[CUR]), 64'd0);

        // R5 again after dry stop
        s = sends;
        pulse_done();
        check(sends == s && !out_en, "R5 stays idle after stop", 64'(sends), 64'(s));

        // Refill with D(2) and resume with start
        load_pkt(32'h50, 2, 0);
        mem[RDY] = {18'h50, 18'h50};
        expect_pkt(32'h50);
        pulse_start();
        check(out_en == 1'b1, "R2 start resumes", 64'(out_en), 64'd1);
        pulse_done();
        pulse_done();
        pulse_done();
        check(!out_en, "R9 dry again after D", 64'(out_en), 64'd0);
        check(mem[DNQ] == {18'h20, 18'h50}, "R8 D appended", 64'(mem[DNQ]), 64'({18'h20, 18'h50}));
        check(mem[32'h40][17:0] == 18'h50, "R8 C linked to D", 64'(mem[32'h40][17:0]), 64'h50);
        check(exp_q.size() == 0, "R7 all expected halfwords sent", 64'(exp_q.size()), 64'd0);

        finish_run();
    end

endmodule